// File: doc/BRIEF.md
# Copy-Back Operand Cache

This block is a direct-mapped data cache of 16 KB, organised as 512 lines of 32 bytes, that sits between a processor load/store port and an external memory that moves whole lines. Loads and stores of one, two or four bytes that hit are served from the line array. A miss stalls the processor port and fetches the line. If the line being replaced holds modified data, it is first burst-written to the address it came from. Stores only update the cache and mark the line modified.

Besides plain loads and stores, the same request port carries several maintenance operations. Prefetch brings a line in without returning data. Invalidate drops a matching line. Purge drops a matching line after saving it if it is modified. Write-back saves a modified line but keeps it resident. Two further commands read and write the tag array directly. A separate input drops every line at once.

Top module: `dcache_cb`

## Requirements
- R1: A load that hits returns data from the line: size code 2 returns the aligned 32-bit word, size code 1 returns the 16-bit half sign-extended to 32 bits, size code 0 returns the byte sign-extended to 32 bits. Op codes: 0 load, 1 store, 2 prefetch, 3 invalidate, 4 purge, 5 write-back, 6 tag read, 7 tag write.
- R2: A store (op 1) updates only the addressed bytes and sets the line's modified flag. A later load of those bytes returns the stored value.
- R3: Only address bits 28:0 are used. A load, store or prefetch that misses issues one line read at the line address (bits 4:0 zero), installs the line, and then completes the access.
- R4: On a miss whose victim is valid and modified, the victim line is written to its old address (stored tag bits 28:10 plus index bits 9:5) before the new line is read. A clean victim causes no write.
- R5: Invalidate (op 3) on a hit clears the valid flag, leaves the modified flag as it was and causes no memory traffic. A later load re-reads memory.
- R6: Purge (op 4) on a hit writes the line to memory first if it is modified, then leaves it with both flags clear.
- R7: Write-back (op 5) on a valid modified hit writes the line to memory, clears the modified flag and keeps the line valid. On a clean line it causes no traffic.
- R8: Tag read (op 6) of the line indexed by address bits 13:5 returns the stored tag in bits 28:10, the modified flag in bit 1, the valid flag in bit 0 and zero elsewhere.
- R9: Tag write (op 7) with address bit 3 clear first writes the indexed line back if it is valid and modified. It then sets the tag from data bits 28:10, valid from data bit 0 and modified from data bit 1. With address bit 3 set, it changes nothing.
- R10: Reset leaves every tag and flag clear. A one-cycle pulse on inv_all clears every valid flag without writing anything back.
- R11: req_ready is low whenever a memory transfer is pending. A memory request holds its address and direction until mem_ack. Each operation gives exactly one single-cycle rsp_valid.
- R12: Prefetch (op 2) fills a missing line exactly like a load but responds with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear all valid flags |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 3 | Operation code |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data or tag-write data |
| rsp_valid | output | 1 | Operation complete, one cycle |
| rsp_rdata | output | 32 | Load or tag-read result, zero otherwise |
| mem_req | output | 1 | Line transfer request, held until acknowledged |
| mem_we | output | 1 | 1 write line to memory, 0 read line |
| mem_addr | output | 29 | Line address |
| mem_wline | output | 256 | Line written to memory |
| mem_ack | input | 1 | Transfer done; read line valid this cycle |
| mem_rline | input | 256 | Line read from memory |

## Verification
On every cycle, the assertions check the memory handshake and the stall behaviour. After a fill acknowledge they check that the line is valid, and after a write-back acknowledge that it is clean. They also check that the global clear leaves no valid line and that responses are single pulses. Only the bench scenarios can show the data-level behaviour: the order and addresses of victim write-back and refill, the sign extension of narrow loads, which maintenance operations move data and which do not, and the tag-port encoding and retagging.

// File: rtl/dcache_cb.sv
`timescale 1ns/1ps
module dcache_cb #(
  parameter int ADDR_W     = 29,
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inv_all,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic [1:0]              req_size,
  input  logic [31:0]             req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wline,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rline
);
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(LINES);
  localparam int TAG_LO    = 10;
  localparam int TAG_W     = ADDR_W - TAG_LO;
  localparam int SH_W      = OFF_W + 3;

  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_PF = 3'd2, OP_INV = 3'd3,
                         OP_PRG = 3'd4, OP_WBK = 3'd5, OP_TRD = 3'd6, OP_TWR = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_WB, S_FILL} state_t;

  state_t                 state_q;
  logic [2:0]             op_q;
  logic [1:0]             size_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [31:0]            wdata_q;
  logic [LINES-1:0]       valid_q, dirty_q;
  logic [TAG_W-1:0]       tag_q  [LINES];
  logic [LINE_BITS-1:0]   data_q [LINES];
  logic                   rsp_valid_q;
  logic [31:0]            rsp_rdata_q;

  logic [IDX_W-1:0]       idx;
  logic [OFF_W-1:0]       off, off_al;
  logic [TAG_W-1:0]       cur_tag;
  logic [LINE_BITS-1:0]   cur_line, new_line, wshift, raw;
  logic [LINE_BYTES-1:0]  bmask;
  logic [SH_W-1:0]        sh;
  logic [3:0]             nb;
  logic                   hit, vdirty, done, go_wb, go_fill;
  logic [31:0]            ld_data, tag_word;

  assign idx      = addr_q[OFF_W +: IDX_W];
  assign off      = addr_q[OFF_W-1:0];
  assign cur_tag  = tag_q[idx];
  assign cur_line = data_q[idx];
  assign hit      = valid_q[idx] && (cur_tag == addr_q[ADDR_W-1:TAG_LO]);
  assign vdirty   = valid_q[idx] && dirty_q[idx];

  assign req_ready = (state_q == S_IDLE);
  assign mem_req   = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = (state_q == S_WB) ? {cur_tag, addr_q[TAG_LO-1:OFF_W], {OFF_W{1'b0}}}
                                       : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wline = cur_line;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  always_comb begin
    case (size_q)
      2'd0:    begin off_al = off;                     nb = 4'b0001; end
      2'd1:    begin off_al = {off[OFF_W-1:1], 1'b0};  nb = 4'b0011; end
      default: begin off_al = {off[OFF_W-1:2], 2'b00}; nb = 4'b1111; end
    endcase
    sh     = {off_al, 3'b000};
    raw    = cur_line >> sh;
    bmask  = LINE_BYTES'(nb) << off_al;
    wshift = LINE_BITS'(wdata_q) << sh;
    for (int b = 0; b < LINE_BYTES; b++)
      new_line[b*8 +: 8] = bmask[b] ? wshift[b*8 +: 8] : cur_line[b*8 +: 8];
    case (size_q)
      2'd0:    ld_data = {{24{raw[7]}}, raw[7:0]};
      2'd1:    ld_data = {{16{raw[15]}}, raw[15:0]};
      default: ld_data = raw[31:0];
    endcase
    tag_word = '0;
    tag_word[ADDR_W-1:TAG_LO] = cur_tag;
    tag_word[1:0] = {dirty_q[idx], valid_q[idx]};
  end

  always_comb begin
    done = 1'b0; go_wb = 1'b0; go_fill = 1'b0;
    case (op_q)
      OP_LD, OP_ST, OP_PF: begin
        if (hit)         done    = 1'b1;
        else if (vdirty) go_wb   = 1'b1;
        else             go_fill = 1'b1;
      end
      OP_PRG, OP_WBK: begin
        if (hit && dirty_q[idx]) go_wb = 1'b1;
        else                     done  = 1'b1;
      end
      OP_TWR: begin
        if (!addr_q[3] && vdirty) go_wb = 1'b1;
        else                      done  = 1'b1;
      end
      default: done = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      op_q        <= OP_LD;
      size_q      <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          size_q  <= req_size;
          addr_q  <= req_addr[ADDR_W-1:0];
          wdata_q <= req_wdata;
          state_q <= S_ACT;
        end
        S_ACT: begin
          if (done) begin
            state_q     <= S_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= (op_q == OP_LD) ? ld_data : (op_q == OP_TRD) ? tag_word : '0;
          end else if (go_wb) state_q <= S_WB;
          else if (go_fill)   state_q <= S_FILL;
        end
        default: if (mem_ack) state_q <= S_ACT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      if (state_q == S_WB && mem_ack) dirty_q[idx] <= 1'b0;
      if (state_q == S_FILL && mem_ack) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
        tag_q[idx]   <= addr_q[ADDR_W-1:TAG_LO];
      end
      if (state_q == S_ACT && done) begin
        case (op_q)
          OP_ST:          dirty_q[idx] <= 1'b1;
          OP_INV, OP_PRG: if (hit) valid_q[idx] <= 1'b0;
          OP_TWR: if (!addr_q[3]) begin
            tag_q[idx]   <= wdata_q[ADDR_W-1:TAG_LO];
            valid_q[idx] <= wdata_q[0];
            dirty_q[idx] <= wdata_q[1];
          end
          default: ;
        endcase
      end
      if (inv_all) valid_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_FILL && mem_ack)
      data_q[idx] <= mem_rline;
    else if (state_q == S_ACT && done && op_q == OP_ST)
      data_q[idx] <= new_line;
  end
endmodule

// File: rtl/dcache_cb_chk.sv
`timescale 1ns/1ps
module dcache_cb_chk #(
  parameter int ADDR_W = 29,
  parameter int LINES  = 512
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     inv_all,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     mem_req,
  input logic                     mem_we,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic                     mem_ack,
  input logic [LINES-1:0]         valid_q,
  input logic [LINES-1:0]         dirty_q,
  input logic [$clog2(LINES)-1:0] idx
);
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> valid_q == '0);

  p_fill_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && !inv_all |=> valid_q[$past(idx)]);

  p_wb_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> !dirty_q[$past(idx)]);

  p_wb_then_lookup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> !mem_req);
endmodule

bind dcache_cb dcache_cb_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .valid_q(valid_q), .dirty_q(dirty_q), .idx(idx));

// File: tb/sim_dcache_cb.sv
`timescale 1ns/1ps
module sim_dcache_cb;
  logic clk = 0, rst_n = 0, inv_all = 0;
  logic req_valid = 0, req_ready;
  logic [2:0] req_op = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [28:0] mem_addr;
  logic [255:0] mem_wline, mem_rline = '0;

  always #4 clk = ~clk;

  dcache_cb u0 (.clk, .rst_n, .inv_all, .req_valid, .req_ready, .req_op, .req_size,
    .req_addr, .req_wdata, .rsp_valid, .rsp_rdata, .mem_req, .mem_we, .mem_addr,
    .mem_wline, .mem_ack, .mem_rline);

  int total = 0, bad = 0, pending = 0, viol = 0;
  logic [31:0] exp_q[$];
  string       rq_q[$];
  logic [255:0] ext [int];
  logic [255:0] gold [int];
  int log_addr[$];
  bit log_we[$];

  task automatic check(input string r, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [255:0] init_line(int la);
    logic [255:0] l;
    for (int k = 0; k < 8; k++)
      l[k*32 +: 32] = {8'(k * 17), 8'(la >> 5), 8'h90 + 8'(k), 8'hF0 ^ 8'(k)};
    return l;
  endfunction
  function automatic logic [255:0] ext_line(int la);
    return ext.exists(la) ? ext[la] : init_line(la);
  endfunction
  function automatic logic [255:0] gold_line(int la);
    return gold.exists(la) ? gold[la] : ext_line(la);
  endfunction
  function automatic logic [31:0] exp_rd(int a, int s);
    logic [255:0] l = gold_line(a & 32'h1FFFFFE0);
    int o = a & 31;
    logic [31:0] w;
    if (s == 0) begin w = 32'(l[o*8 +: 8]);  return {{24{w[7]}},  w[7:0]}; end
    if (s == 1) begin o = o & ~1; w = 32'(l[o*8 +: 16]); return {{16{w[15]}}, w[15:0]}; end
    o = o & ~3;
    return l[o*8 +: 32];
  endfunction
  task automatic gold_write(int a, int s, logic [31:0] v);
    int la = a & 32'h1FFFFFE0;
    logic [255:0] l = gold_line(la);
    int o = a & 31;
    int n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    if (s == 1) o = o & ~1;
    if (s == 2) o = o & ~3;
    for (int b = 0; b < n; b++) l[(o+b)*8 +: 8] = v[b*8 +: 8];
    gold[la] = l;
  endtask

  // memory responder
  initial forever begin
    @(negedge clk);
    mem_ack = 0;
    if (mem_req) begin
      automatic int a = int'(mem_addr);
      automatic bit w = mem_we;
      automatic logic [255:0] wl = mem_wline;
      repeat (2) @(negedge clk);
      if (int'(mem_addr) != a || mem_we != w) viol++;
      log_addr.push_back(a); log_we.push_back(w);
      if (w) ext[a] = wl; else mem_rline = ext_line(a);
      mem_ack = 1;
    end
  end

  always @(negedge clk) if (rst_n && mem_req && req_ready) viol++;

  // monitor
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) check("R11 unexpected response", 1, 0);
    else begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string r = rq_q.pop_front();
      check(r, rsp_rdata, e);
      pending--;
    end
  end

  task automatic do_op(input logic [2:0] o, input logic [1:0] s, input logic [31:0] a,
                       input logic [31:0] wd, input logic [31:0] ex, input string r);
    log_addr.delete(); log_we.delete();
    exp_q.push_back(ex); rq_q.push_back(r); pending++;
    @(negedge clk);
    req_valid = 1; req_op = o; req_size = s; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    wait (pending == 0);
    @(negedge clk);
  endtask

  task automatic chk_log(input string r, input int n, input int i, input bit w, input int a);
    check({r, " traffic count"}, 256'(log_addr.size()), 256'(n));
    if (log_addr.size() > i) begin
      check({r, " traffic dir"}, 256'(log_we[i]), 256'(w));
      check({r, " traffic addr"}, 256'(log_addr[i]), 256'(a));
    end
  endtask

  initial begin
    #(8ns * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] victim;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset ready", 256'(req_ready), 1);
    check("R10 reset no mem req", 256'(mem_req), 0);
    check("R11 reset no response", 256'(rsp_valid), 0);
    do_op(6, 2, 32'h0, 0, 32'h0, "R10 R8 tag clear after reset");

    do_op(0, 2, 32'hA000_1044, 0, exp_rd(32'h1044, 2), "R3 miss load word");
    chk_log("R3", 1, 0, 0, 32'h1040);
    do_op(0, 1, 32'h1042, 0, exp_rd(32'h1042, 1), "R1 half sign extend");
    chk_log("R1", 0, 0, 0, 0);
    do_op(0, 0, 32'h1040, 0, exp_rd(32'h1040, 0), "R1 byte sign extend");
    check("R1 byte negative", 256'(exp_rd(32'h1040, 0) >> 31), 1);

    do_op(1, 0, 32'h1041, 32'h80, 0, "R2 store byte");
    gold_write(32'h1041, 0, 32'h80);
    do_op(0, 2, 32'h1040, 0, exp_rd(32'h1040, 2), "R2 reload after store");
    do_op(6, 2, 32'h1040, 0, 32'h0000_1003, "R8 R2 tag read dirty");

    victim = gold_line(32'h1040);
    do_op(0, 2, 32'h5040, 0, exp_rd(32'h5040, 2), "R4 conflict load");
    chk_log("R4 victim first", 2, 0, 1, 32'h1040);
    chk_log("R4 refill second", 2, 1, 0, 32'h5040);
    check("R4 victim data", ext_line(32'h1040), victim);
    do_op(0, 0, 32'h1041, 0, 32'hFFFF_FF80, "R4 data survives eviction");
    chk_log("R4 clean victim", 1, 0, 0, 32'h1040);

    do_op(1, 2, 32'h1048, 32'h0BAD_F00D, 0, "R2 store word");
    gold_write(32'h1048, 2, 32'h0BAD_F00D);
    do_op(5, 2, 32'h1040, 0, 0, "R7 writeback op");
    chk_log("R7", 1, 0, 1, 32'h1040);
    check("R7 data in memory", ext_line(32'h1040), gold_line(32'h1040));
    do_op(6, 2, 32'h1040, 0, 32'h0000_1001, "R7 valid kept dirty cleared");
    do_op(5, 2, 32'h1040, 0, 0, "R7 writeback clean");
    chk_log("R7 clean", 0, 0, 0, 0);

    do_op(1, 1, 32'h1044, 32'hFFFF_8765, 0, "R2 store half");
    gold_write(32'h1044, 1, 32'hFFFF_8765);
    do_op(4, 2, 32'h1040, 0, 0, "R6 purge dirty");
    chk_log("R6", 1, 0, 1, 32'h1040);
    do_op(6, 2, 32'h1040, 0, 32'h0000_1000, "R6 flags clear");
    do_op(0, 1, 32'h1044, 0, 32'hFFFF_8765, "R6 data refetched");
    chk_log("R6 refill", 1, 0, 0, 32'h1040);

    do_op(1, 2, 32'h1044, 32'hDEAD_BEEF, 0, "R2 store before invalidate");
    do_op(3, 2, 32'h1040, 0, 0, "R5 invalidate");
    chk_log("R5 no traffic", 0, 0, 0, 0);
    do_op(6, 2, 32'h1040, 0, 32'h0000_1002, "R5 valid clear dirty kept");
    gold.delete(32'h1040);
    do_op(0, 2, 32'h1044, 0, exp_rd(32'h1044, 2), "R5 store discarded");
    chk_log("R5 refetch", 1, 0, 0, 32'h1040);

    do_op(2, 2, 32'h2000, 0, 0, "R12 prefetch response zero");
    chk_log("R12", 1, 0, 0, 32'h2000);
    do_op(0, 2, 32'h2004, 0, exp_rd(32'h2004, 2), "R12 prefetched line hits");
    chk_log("R12 hit", 0, 0, 0, 0);

    do_op(1, 2, 32'h2004, 32'hCAFE_F00D, 0, "R2 store for retag");
    gold_write(32'h2004, 2, 32'hCAFE_F00D);
    do_op(7, 2, 32'h2000, 32'h0000_6001, 0, "R9 tag write");
    chk_log("R9 old line written back", 1, 0, 1, 32'h2000);
    gold[32'h6000] = gold_line(32'h2000);
    do_op(6, 2, 32'h2000, 0, 32'h0000_6001, "R9 new tag and flags");
    do_op(0, 2, 32'h6004, 0, 32'hCAFE_F00D, "R9 retagged line hits");
    chk_log("R9 hit", 0, 0, 0, 0);
    do_op(7, 2, 32'h2008, 32'h0, 0, "R9 associative write");
    do_op(6, 2, 32'h2000, 0, 32'h0000_6001, "R9 associative write no effect");
    chk_log("R9 assoc", 0, 0, 0, 0);

    do_op(1, 2, 32'h3000, 32'h0123_4567, 0, "R2 store miss");
    chk_log("R3 store miss fill", 1, 0, 0, 32'h3000);
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    gold.delete();
    do_op(6, 2, 32'h3000, 0, 32'h0000_3002, "R10 global clear");
    do_op(0, 2, 32'h3000, 0, exp_rd(32'h3000, 2), "R10 store dropped");
    chk_log("R10 refetch only", 1, 0, 0, 32'h3000);

    check("R11 ready low and request stable while busy", 256'(viol), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule